// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a segment-relative memory reference into a physical byte address the way a real-mode processor does. It holds six 16-bit segment registers, and each can be written synchronously from a single write port. For each reference the caller gives an access kind, up to two offset components and a displacement. The block picks the segment register that the access kind implies, or an explicit override where that is allowed. It shifts the segment value left by four bits to form a paragraph-aligned base and adds the effective offset to it.

The address path is purely combinational from the current register contents and the request inputs, so an address-generation stage can use it in the same cycle. Each segment spans 64K bytes. When the summed offset does not fit in 16 bits, an error flag is raised. The result is 21 bits wide. A runtime enable chooses between keeping the carry out of bit 19, which makes the region just above 1 MB reachable, and wrapping the address to 20 bits.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, every segment register reads zero except the code register, which reads the parameter CS_RST (default F000h). Segment identifiers are: 0 = extra (ES), 1 = code (CS), 2 = stack (SS), 3 = data (DS), 4 = FS, 5 = GS.
- R2: When seg_wr_en is high at a rising clock edge, the register named by seg_wr_sel takes seg_wr_data, and no other register changes.
- R3: The physical address is the selected segment value times 16, plus the low 16 bits of the effective offset.
- R4: For access kind 0 (fetch), the code register is used, the effective offset is off_a alone, and off_b and disp have no effect on the address or on the error flag.
- R5: Access kind 1 (stack) uses the stack register. Access kind 2 (data) with bp_based high also uses the stack register.
- R6: Access kind 2 (data) with bp_based low uses the data register. Access kind 3 (string destination) uses the extra register.
- R7: For access kinds 1 and 2, ovr_en high with an ovr_sel value of 0 to 5 selects that register instead of the default.
- R8: The override is ignored for access kinds 0 and 3, and for ovr_sel values 6 and 7.
- R9: For access kinds 1 to 3, the effective offset is off_a + off_b + disp, computed without loss.
- R10: addr_err is high exactly when the full effective offset exceeds FFFFh. The address then uses only the low 16 bits of the offset.
- R11: With hma_en high, the carry out of bit 19 appears in bit 20. Segment FFFFh therefore reaches addresses FFFF0h through 10FFEFh.
- R12: With hma_en low, bit 20 is zero and the address wraps modulo 2^20.
- R13: A segment write takes effect after the clock edge. An address formed in the same cycle as the write uses the old value.
- R14: A write with seg_wr_sel of 6 or 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 3 | Identifier of the register to write |
| seg_wr_data | input | 16 | Value to write |
| acc_kind | input | 2 | 0 fetch, 1 stack, 2 data, 3 string destination |
| bp_based | input | 1 | Data access is addressed through the base pointer |
| ovr_en | input | 1 | Segment override requested |
| ovr_sel | input | 3 | Identifier of the override register |
| off_a | input | 16 | First offset component (instruction pointer on fetch) |
| off_b | input | 16 | Second offset component |
| disp | input | 16 | Displacement |
| hma_en | input | 1 | Keep the carry into bit 20 |
| phys_addr | output | 21 | Physical byte address |
| addr_err | output | 1 | Effective offset exceeds 16 bits |

## Verification
A segment register write and an address computation that reads the same register can occur in the same cycle. The bench provokes this by starting a write to the data register while a data access is presented. It first checks that the address, sampled before the edge, is still built from the old value. It then checks that the address sampled just after the edge is built from the new value, with the request inputs held unchanged. Alongside this, a near-exhaustive sweep crosses every access kind, base-pointer flag, override code and high-memory setting, and compares each result against arithmetic done in the bench.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

   localparam int SEG_IDX_W = 3;
   localparam int NUM_SEGS  = 6;

   typedef enum logic [SEG_IDX_W-1:0] {
      SEG_ES = 3'd0,
      SEG_CS = 3'd1,
      SEG_SS = 3'd2,
      SEG_DS = 3'd3,
      SEG_FS = 3'd4,
      SEG_GS = 3'd5
   } seg_id_e;

   typedef enum logic [1:0] {
      ACC_FETCH  = 2'd0,
      ACC_STACK  = 2'd1,
      ACC_DATA   = 2'd2,
      ACC_STRDST = 2'd3
   } acc_kind_e;

   function automatic logic seg_id_valid(input logic [SEG_IDX_W-1:0] id);
      return id < SEG_IDX_W'(NUM_SEGS);
   endfunction

   function automatic logic kind_takes_override(input acc_kind_e k);
      return (k == ACC_STACK) || (k == ACC_DATA);
   endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
   import seg_addr_pkg::*;
#(
   parameter int                SEG_W  = 16,
   parameter logic [SEG_W-1:0]  CS_RST = 16'hF000
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [SEG_IDX_W-1:0]                wr_sel,
   input  logic [SEG_W-1:0]                    wr_data,
   output logic [NUM_SEGS-1:0][SEG_W-1:0]      seg_q
);

   for (genvar i = 0; i < NUM_SEGS; i++) begin : g_seg
      localparam logic [SEG_W-1:0] RST_VAL =
         (i == int'(SEG_CS)) ? CS_RST : '0;
      logic hit;
      assign hit = wr_en && (wr_sel == SEG_IDX_W'(i));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            seg_q[i] <= RST_VAL;
         end else if (hit) begin
            seg_q[i] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/seg_select.sv
module seg_select
   import seg_addr_pkg::*;
#(
   parameter int SEG_W = 16
) (
   input  logic [1:0]                         acc_kind,
   input  logic                               bp_based,
   input  logic                               ovr_en,
   input  logic [SEG_IDX_W-1:0]               ovr_sel,
   input  logic [NUM_SEGS-1:0][SEG_W-1:0]     seg_q,
   output logic [SEG_W-1:0]                   seg_val
);

   acc_kind_e              kind;
   logic [SEG_IDX_W-1:0]   dflt_id;
   logic [SEG_IDX_W-1:0]   use_id;
   logic                   ovr_ok;

   assign kind = acc_kind_e'(acc_kind);

   always_comb begin
      unique case (kind)
         ACC_FETCH: dflt_id = SEG_CS;
         ACC_STACK: dflt_id = SEG_SS;
         ACC_DATA:  dflt_id = bp_based ? SEG_SS : SEG_DS;
         default:   dflt_id = SEG_ES;
      endcase
   end

   assign ovr_ok = ovr_en && seg_id_valid(ovr_sel) && kind_takes_override(kind);
   assign use_id = ovr_ok ? ovr_sel : dflt_id;

   always_comb begin
      seg_val = '0;
      for (int i = 0; i < NUM_SEGS; i++) begin
         if (use_id == SEG_IDX_W'(i)) seg_val = seg_q[i];
      end
   end

endmodule

// File: rtl/offset_adder.sv
module offset_adder
   import seg_addr_pkg::*;
#(
   parameter int OFF_W = 16
) (
   input  logic [1:0]        acc_kind,
   input  logic [OFF_W-1:0]  off_a,
   input  logic [OFF_W-1:0]  off_b,
   input  logic [OFF_W-1:0]  disp,
   output logic [OFF_W-1:0]  eff_off,
   output logic              oversize
);

   localparam int SUM_W = OFF_W + 2;

   logic [SUM_W-1:0] tot;

   always_comb begin
      tot = {2'b00, off_a};
      if (acc_kind_e'(acc_kind) != ACC_FETCH) begin
         tot = tot + {2'b00, off_b} + {2'b00, disp};
      end
   end

   assign eff_off  = tot[OFF_W-1:0];
   assign oversize = |tot[SUM_W-1:OFF_W];

endmodule

// File: rtl/addr_combiner.sv
module addr_combiner #(
   parameter int SEG_W    = 16,
   parameter int OFF_W    = 16,
   parameter int SHIFT    = 4,
   parameter int HMA_IMPL = 1
) (
   input  logic [SEG_W-1:0]         seg_val,
   input  logic [OFF_W-1:0]         eff_off,
   input  logic                     hma_en,
   output logic [SEG_W+SHIFT:0]     phys
);

   localparam int BASE_W = SEG_W + SHIFT;
   localparam int ADDR_W = BASE_W + 1;

   logic [ADDR_W-1:0] full;

   assign full = {1'b0, seg_val, {SHIFT{1'b0}}} + ADDR_W'(eff_off);

   if (HMA_IMPL != 0) begin : g_hma
      assign phys = hma_en ? full : {1'b0, full[BASE_W-1:0]};
   end else begin : g_wrap
      logic unused_hi;
      assign unused_hi = full[BASE_W] ^ hma_en;
      assign phys      = {1'b0, full[BASE_W-1:0]};
   end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int                SEG_W    = 16,
   parameter int                OFF_W    = 16,
   parameter int                SHIFT    = 4,
   parameter int                HMA_IMPL = 1,
   parameter logic [SEG_W-1:0]  CS_RST   = 16'hF000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     seg_wr_en,
   input  logic [2:0]               seg_wr_sel,
   input  logic [SEG_W-1:0]         seg_wr_data,
   input  logic [1:0]               acc_kind,
   input  logic                     bp_based,
   input  logic                     ovr_en,
   input  logic [2:0]               ovr_sel,
   input  logic [OFF_W-1:0]         off_a,
   input  logic [OFF_W-1:0]         off_b,
   input  logic [OFF_W-1:0]         disp,
   input  logic                     hma_en,
   output logic [SEG_W+SHIFT:0]     phys_addr,
   output logic                     addr_err
);

   localparam int BASE_W = SEG_W + SHIFT;

   if (SEG_W < 1) begin : g_bad_seg
      $error("seg_addr_gen: SEG_W must be positive");
   end
   if (SHIFT < 1) begin : g_bad_shift
      $error("seg_addr_gen: SHIFT must be positive");
   end
   if (OFF_W > BASE_W) begin : g_bad_off
      $error("seg_addr_gen: OFF_W must not exceed SEG_W + SHIFT");
   end

   logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q;
   logic [SEG_W-1:0]               seg_val;
   logic [OFF_W-1:0]               eff_off;

   seg_regfile #(
      .SEG_W  (SEG_W),
      .CS_RST (CS_RST)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (seg_wr_en),
      .wr_sel  (seg_wr_sel),
      .wr_data (seg_wr_data),
      .seg_q   (seg_q)
   );

   seg_select #(
      .SEG_W (SEG_W)
   ) u_sel (
      .acc_kind (acc_kind),
      .bp_based (bp_based),
      .ovr_en   (ovr_en),
      .ovr_sel  (ovr_sel),
      .seg_q    (seg_q),
      .seg_val  (seg_val)
   );

   offset_adder #(
      .OFF_W (OFF_W)
   ) u_off (
      .acc_kind (acc_kind),
      .off_a    (off_a),
      .off_b    (off_b),
      .disp     (disp),
      .eff_off  (eff_off),
      .oversize (addr_err)
   );

   addr_combiner #(
      .SEG_W    (SEG_W),
      .OFF_W    (OFF_W),
      .SHIFT    (SHIFT),
      .HMA_IMPL (HMA_IMPL)
   ) u_comb (
      .seg_val (seg_val),
      .eff_off (eff_off),
      .hma_en  (hma_en),
      .phys    (phys_addr)
   );

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter int SHIFT = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  seg_wr_en,
   input logic [1:0]            acc_kind,
   input logic                  bp_based,
   input logic                  ovr_en,
   input logic [2:0]            ovr_sel,
   input logic [OFF_W-1:0]      off_a,
   input logic [OFF_W-1:0]      off_b,
   input logic [OFF_W-1:0]      disp,
   input logic                  hma_en,
   input logic [SEG_W+SHIFT:0]  phys_addr,
   input logic                  addr_err
);

   // R4
   fetch_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind == 2'd0) |-> !addr_err);

   // R4
   fetch_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind == 2'd0) |-> (phys_addr[SHIFT-1:0] == off_a[SHIFT-1:0]));

   // R10
   single_term_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (off_b == '0 && disp == '0) |-> !addr_err);

   // R12
   wrap_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hma_en |-> !phys_addr[SEG_W+SHIFT]);

   // R13
   hold_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(seg_wr_en) && $stable(acc_kind) && $stable(bp_based) &&
       $stable(ovr_en) && $stable(ovr_sel) && $stable(off_a) &&
       $stable(off_b) && $stable(disp) && $stable(hma_en))
      |-> ($stable(phys_addr) && $stable(addr_err)));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
   .SEG_W (SEG_W),
   .OFF_W (OFF_W),
   .SHIFT (SHIFT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .seg_wr_en (seg_wr_en),
   .acc_kind  (acc_kind),
   .bp_based  (bp_based),
   .ovr_en    (ovr_en),
   .ovr_sel   (ovr_sel),
   .off_a     (off_a),
   .off_b     (off_b),
   .disp      (disp),
   .hma_en    (hma_en),
   .phys_addr (phys_addr),
   .addr_err  (addr_err)
);

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        seg_wr_en;
   logic [2:0]  seg_wr_sel;
   logic [15:0] seg_wr_data;
   logic [1:0]  acc_kind;
   logic        bp_based;
   logic        ovr_en;
   logic [2:0]  ovr_sel;
   logic [15:0] off_a;
   logic [15:0] off_b;
   logic [15:0] disp;
   logic        hma_en;
   logic [20:0] phys_addr;
   logic        addr_err;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   logic [15:0] shadow [6];
   logic [31:0] lcg = 32'h1234_5678;

   always #4 clk = ~clk;

   seg_addr_gen uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .seg_wr_en   (seg_wr_en),
      .seg_wr_sel  (seg_wr_sel),
      .seg_wr_data (seg_wr_data),
      .acc_kind    (acc_kind),
      .bp_based    (bp_based),
      .ovr_en      (ovr_en),
      .ovr_sel     (ovr_sel),
      .off_a       (off_a),
      .off_b       (off_b),
      .disp        (disp),
      .hma_en      (hma_en),
      .phys_addr   (phys_addr),
      .addr_err    (addr_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int exp_seg(input int kind, input bit bp, input bit oe, input int os);
      int d;
      case (kind)
         0: d = 1;
         1: d = 2;
         2: d = bp ? 2 : 3;
         default: d = 0;
      endcase
      if (oe && os < 6 && (kind == 1 || kind == 2)) d = os;
      return d;
   endfunction

   function automatic logic [20:0] exp_phys(input logic [15:0] seg, input logic [17:0] eff,
                                            input bit hma);
      logic [20:0] s;
      s = {1'b0, seg, 4'h0} + {5'd0, eff[15:0]};
      if (!hma) s[20] = 1'b0;
      return s;
   endfunction

   task automatic drive(input int kind, input bit bp, input bit oe, input int os,
                        input logic [15:0] a, input logic [15:0] b, input logic [15:0] d,
                        input bit hma);
      @(negedge clk);
      acc_kind = 2'(kind);
      bp_based = bp;
      ovr_en   = oe;
      ovr_sel  = 3'(os);
      off_a    = a;
      off_b    = b;
      disp     = d;
      hma_en   = hma;
      #1;
   endtask

   task automatic write_seg(input int sel, input logic [15:0] val);
      @(negedge clk);
      seg_wr_en   = 1'b1;
      seg_wr_sel  = 3'(sel);
      seg_wr_data = val;
      @(negedge clk);
      seg_wr_en   = 1'b0;
      if (sel < 6) shadow[sel] = val;
   endtask

   task automatic read_all(input string tag);
      for (int i = 0; i < 6; i++) begin
         drive(2, 0, 1, i, 16'h0, 16'h0, 16'h0, 1'b1);
         check(tag, 32'(phys_addr), 32'({1'b0, shadow[i], 4'h0}));
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; seg_wr_en = 1'b0; seg_wr_sel = '0; seg_wr_data = '0;
      acc_kind = '0; bp_based = 1'b0; ovr_en = 1'b0; ovr_sel = '0;
      off_a = '0; off_b = '0; disp = '0; hma_en = 1'b1;
      for (int i = 0; i < 6; i++) shadow[i] = (i == 1) ? 16'hF000 : 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset contents seen through override reads
      read_all("R1 reset value");

      // R2 writes to each register
      write_seg(0, 16'h1234);
      write_seg(1, 16'h2000);
      write_seg(2, 16'h3000);
      write_seg(3, 16'h4000);
      write_seg(4, 16'h5678);
      write_seg(5, 16'hFFFF);
      read_all("R2 write");

      // R14 out-of-range write selectors
      write_seg(6, 16'hDEAD);
      write_seg(7, 16'hBEEF);
      read_all("R14 invalid write ignored");

      // R4 fetch: CS + IP, other terms ignored
      drive(0, 0, 0, 0, 16'h0100, 16'hFFFF, 16'hFFFF, 1'b1);
      check("R4 fetch address", 32'(phys_addr), 32'h20100);
      check("R4 fetch no error", 32'(addr_err), 32'h0);
      // R8 override ignored on fetch
      drive(0, 0, 1, 5, 16'h0100, 16'h0000, 16'h0000, 1'b1);
      check("R8 fetch override ignored", 32'(phys_addr), 32'h20100);

      // R5 stack and base-pointer data
      drive(1, 0, 0, 0, 16'h0010, 16'h0000, 16'h0000, 1'b1);
      check("R5 stack uses SS", 32'(phys_addr), 32'h30010);
      drive(2, 1, 0, 0, 16'h0020, 16'h0000, 16'h0000, 1'b1);
      check("R5 bp data uses SS", 32'(phys_addr), 32'h30020);

      // R6 data and string destination defaults
      drive(2, 0, 0, 0, 16'h0030, 16'h0000, 16'h0000, 1'b1);
      check("R6 data uses DS", 32'(phys_addr), 32'h40030);
      drive(3, 0, 0, 0, 16'h0040, 16'h0000, 16'h0000, 1'b1);
      check("R6 strdst uses ES", 32'(phys_addr), 32'h12380);
      // R8 override ignored on string destination and for code 6
      drive(3, 0, 1, 4, 16'h0040, 16'h0000, 16'h0000, 1'b1);
      check("R8 strdst override ignored", 32'(phys_addr), 32'h12380);
      drive(2, 0, 1, 6, 16'h0030, 16'h0000, 16'h0000, 1'b1);
      check("R8 code 6 ignored", 32'(phys_addr), 32'h40030);

      // R7 override honoured on data and stack
      drive(2, 0, 1, 4, 16'h0001, 16'h0000, 16'h0000, 1'b1);
      check("R7 data override FS", 32'(phys_addr), 32'h56781);
      drive(1, 0, 1, 0, 16'h0002, 16'h0000, 16'h0000, 1'b1);
      check("R7 stack override ES", 32'(phys_addr), 32'h12342);

      // R9 three-term offset
      drive(2, 0, 0, 0, 16'h1000, 16'h0200, 16'h0034, 1'b1);
      check("R9 three-term sum", 32'(phys_addr), 32'h41234);
      // R10 error boundary
      drive(2, 0, 0, 0, 16'hF000, 16'h0F00, 16'h00FF, 1'b1);
      check("R10 FFFFh no error", 32'(addr_err), 32'h0);
      check("R10 FFFFh address", 32'(phys_addr), 32'h4FFFF);
      drive(2, 0, 0, 0, 16'hF000, 16'h3000, 16'h0000, 1'b1);
      check("R10 oversize error", 32'(addr_err), 32'h1);
      check("R10 oversize address", 32'(phys_addr), 32'h42000);
      drive(2, 0, 0, 0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1);
      check("R10 max sum error", 32'(addr_err), 32'h1);

      // R11 and R12 high-memory region via GS = FFFFh
      drive(2, 0, 1, 5, 16'h0010, 16'h0000, 16'h0000, 1'b1);
      check("R11 lowest high byte", 32'(phys_addr), 32'h100000);
      drive(2, 0, 1, 5, 16'hFFFF, 16'h0000, 16'h0000, 1'b1);
      check("R11 highest high byte", 32'(phys_addr), 32'h10FFEF);
      drive(2, 0, 1, 5, 16'h0010, 16'h0000, 16'h0000, 1'b0);
      check("R12 wrap to zero", 32'(phys_addr), 32'h000000);
      drive(2, 0, 1, 5, 16'hFFFF, 16'h0000, 16'h0000, 1'b0);
      check("R12 wrap top", 32'(phys_addr), 32'h0FFEF);

      // R13 write and read of DS in the same cycle
      drive(2, 0, 0, 0, 16'h0005, 16'h0000, 16'h0000, 1'b1);
      seg_wr_en = 1'b1; seg_wr_sel = 3'd3; seg_wr_data = 16'h7000;
      #1;
      check("R13 old value before edge", 32'(phys_addr), 32'h40005);
      @(posedge clk); #1;
      seg_wr_en = 1'b0;
      shadow[3] = 16'h7000;
      check("R13 new value after edge", 32'(phys_addr), 32'h70005);

      // R3 sweep across kinds, overrides and high-memory setting
      for (int kind = 0; kind < 4; kind++)
         for (int bp = 0; bp < 2; bp++)
            for (int oe = 0; oe < 2; oe++)
               for (int os = 0; os < 8; os++)
                  for (int hm = 0; hm < 2; hm++)
                     for (int t = 0; t < 3; t++) begin
                        logic [15:0] a, b, d;
                        logic [17:0] eff;
                        int sidx;
                        lcg = lcg * 32'd1664525 + 32'd1013904223;
                        a = lcg[31:16];
                        lcg = lcg * 32'd1664525 + 32'd1013904223;
                        b = (t == 0) ? 16'h0 : lcg[31:16];
                        lcg = lcg * 32'd1664525 + 32'd1013904223;
                        d = (t == 2) ? lcg[31:16] : lcg[23:16];
                        drive(kind, bp[0], oe[0], os, a, b, d, hm[0]);
                        eff = (kind == 0) ? {2'b00, a}
                                          : {2'b00, a} + {2'b00, b} + {2'b00, d};
                        sidx = exp_seg(kind, bp[0], oe[0], os);
                        check($sformatf("R3 sweep k%0d bp%0d o%0d/%0d h%0d",
                                        kind, bp, oe, os, hm),
                              32'(phys_addr), 32'(exp_phys(shadow[sidx], eff, hm[0])));
                        check($sformatf("R10 sweep k%0d", kind),
                              32'(addr_err), 32'(eff > 18'h0FFFF));
                     end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule